// File: doc/BRIEF.md
# Audio Receive Bit Clock Generator

This block makes the receive bit clock of a serial audio port. Everything runs in one system clock domain. The reference clock, the optional external high-frequency clock, the optional external bit clock and the transmit bit clock all arrive as levels that are already synchronous to `clk`. Each of them must stay high for at least two `clk` cycles and low for at least two.

A first divider counts rising edges of the reference clock and produces an internal high-frequency clock, which can be passed straight or inverted. A source select then picks either that clock or the external high-frequency clock. A second divider counts rising edges of the selected high-frequency clock and produces the internal bit clock. A second source select picks either that clock or the external bit clock.

When the asynchronous-mode input is low, the whole chain is bypassed. The receiver then runs from the inverted transmit bit clock. The block also reports which edge the receiver samples on. It drives an enable that lets the bit clock pin become an output, but only once the internal path has taken up its settings.

Top module: `rx_bclk_gen`

## Requirements
- R1: With `cfg_async`=0, `rx_bclk` equals the inverse of `tx_bclk` one cycle earlier, `rx_sample_rise`=1 and `rx_pin_oe`=0, whatever the other settings are.
- R2: With the high-frequency path internal and not inverted, its clock has a period of `cfg_hf_div`+1 reference periods (1 to 4096). For ratios of 2 and more it is high for ceil(ratio/2) reference periods, starting one cycle after a reference rising edge. For a ratio of 1 it equals the reference level.
- R3: `cfg_hf_invert`=1 inverts the internal high-frequency clock before the source select.
- R4: `cfg_hf_int`=1 selects the internal high-frequency clock and 0 selects `ext_hf_clk`.
- R5: The internal bit clock divides the selected high-frequency clock by `cfg_bit_div`+1 (1 to 32), with the same phase and duty rule as R2.
- R6: With `cfg_async`=1 and `cfg_bit_int`=0, `rx_bclk` equals `ext_bclk` one cycle earlier, and the high-frequency settings and the bit divider have no effect on it.
- R7: With `cfg_async`=1, `rx_sample_rise` equals `cfg_sample_rise` one cycle earlier (1 = rising edge, 0 = falling edge).
- R8: `rx_pin_oe` is 1 only when all of these hold one cycle earlier: asynchronous mode, internal bit clock, `cfg_pin_drive`, the bit divider already holding the requested value, and (if the high-frequency path is internal) the high-frequency divider already holding its requested value. A divider counts as holding its value only after it has loaded a value since reset.
- R9: A new divide value is loaded only at a period boundary of that divider (the input rising edge that ends the current period), so the current period finishes at its old length.
- R10: While `rst` is high, every output is 0 and both dividers clear their counters and stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk | input | 1 | Reference clock level |
| ext_hf_clk | input | 1 | External high-frequency clock level |
| ext_bclk | input | 1 | External bit clock level |
| tx_bclk | input | 1 | Transmit bit clock level |
| cfg_async | input | 1 | 1 = own receive clock path, 0 = inverted transmit clock |
| cfg_hf_int | input | 1 | 1 = internal high-frequency clock |
| cfg_hf_invert | input | 1 | Invert internal high-frequency clock |
| cfg_hf_div | input | 12 | High-frequency ratio minus one |
| cfg_bit_int | input | 1 | 1 = internal bit clock |
| cfg_bit_div | input | 5 | Bit clock ratio minus one |
| cfg_sample_rise | input | 1 | 1 = sample on rising edge |
| cfg_pin_drive | input | 1 | Request to drive the bit clock pin |
| rx_bclk | output | 1 | Receive bit clock (registered) |
| rx_sample_rise | output | 1 | Sampling edge in use (registered) |
| rx_pin_oe | output | 1 | Bit clock pin output enable (registered) |

## Verification
A wrong counter or a wrong stored ratio inside either divider shows up as a bit clock edge in the wrong cycle. The error appears within one period of the affected divider, and the reference model compares `rx_bclk` on every cycle, so it reports the first misplaced edge. A stored value that is loaded at the wrong moment shows as a shortened or stretched period. It also shows on `rx_pin_oe` rising too early or too late, so the enable is compared every cycle as well. Very long ratios (4095 on the first divider) are run for more than one full period so that the wrap of a wide counter is observed.

// File: rtl/rx_bclk_pkg.sv
package rx_bclk_pkg;
  localparam int HF_DIV_W  = 12;
  localparam int BIT_DIV_W = 5;

  typedef enum logic {
    SRC_EXTERNAL = 1'b0,
    SRC_INTERNAL = 1'b1
  } clk_src_e;
endpackage

// File: rtl/rx_bclk_div.sv
module rx_bclk_div #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_lvl,
  input  logic [W-1:0] div,
  output logic         out_lvl,
  output logic         synced
);
  localparam int HW = W + 1;

  logic         in_prev;
  logic         loaded;
  logic [W-1:0] cnt;
  logic [W-1:0] lim;
  logic [HW-1:0] hi_len;
  logic         rise;

  assign rise   = in_lvl & ~in_prev;
  assign hi_len = ({1'b0, lim} + HW'(2)) >> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_prev <= 1'b0;
      cnt     <= '0;
      lim     <= '0;
      loaded  <= 1'b0;
    end else begin
      in_prev <= in_lvl;
      if (rise) begin
        if (cnt == lim) begin
          cnt    <= '0;
          lim    <= div;
          loaded <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign out_lvl = (lim == '0) ? in_lvl : ({1'b0, cnt} < hi_len);
  assign synced  = loaded && (lim == div);

  // R9: counter never runs past the stored limit
  assert_cnt_in_range_R9: assert property (@(posedge clk) disable iff (rst)
    cnt <= lim);

  // R9: stored limit only changes at a period boundary
  assert_load_at_boundary_R9: assert property (@(posedge clk) disable iff (rst)
    (lim != $past(lim)) |-> (cnt == '0));
endmodule

// File: rtl/rx_bclk_out.sv
module rx_bclk_out (
  input  logic clk,
  input  logic rst,
  input  logic async_mode,
  input  logic own_bclk,
  input  logic tx_bclk,
  input  logic sample_rise,
  input  logic pin_ready,
  output logic rx_bclk,
  output logic rx_sample_rise,
  output logic rx_pin_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_bclk        <= 1'b0;
      rx_sample_rise <= 1'b0;
      rx_pin_oe      <= 1'b0;
    end else begin
      rx_bclk        <= async_mode ? own_bclk : ~tx_bclk;
      rx_sample_rise <= async_mode ? sample_rise : 1'b1;
      rx_pin_oe      <= async_mode & pin_ready;
    end
  end

  assert_sync_uses_tx_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!async_mode)) |-> (rx_bclk == !$past(tx_bclk) && !rx_pin_oe));

  assert_reset_quiet_R10: assert property (@(posedge clk)
    $past(rst) |-> (!rx_bclk && !rx_pin_oe && !rx_sample_rise));
endmodule

// File: rtl/rx_bclk_gen.sv
module rx_bclk_gen
  import rx_bclk_pkg::*;
#(
  parameter int HF_W  = HF_DIV_W,
  parameter int BIT_W = BIT_DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_clk,
  input  logic             ext_hf_clk,
  input  logic             ext_bclk,
  input  logic             tx_bclk,
  input  logic             cfg_async,
  input  logic             cfg_hf_int,
  input  logic             cfg_hf_invert,
  input  logic [HF_W-1:0]  cfg_hf_div,
  input  logic             cfg_bit_int,
  input  logic [BIT_W-1:0] cfg_bit_div,
  input  logic             cfg_sample_rise,
  input  logic             cfg_pin_drive,
  output logic             rx_bclk,
  output logic             rx_sample_rise,
  output logic             rx_pin_oe
);
  clk_src_e hf_src, bit_src;
  logic hf_raw, hf_pol, hf_sel, hf_synced;
  logic bit_raw, bit_sel, bit_synced;
  logic pin_ready;

  assign hf_src  = clk_src_e'(cfg_hf_int);
  assign bit_src = clk_src_e'(cfg_bit_int);

  rx_bclk_div #(.W(HF_W)) u_hf_div (
    .clk(clk), .rst(rst), .in_lvl(ref_clk), .div(cfg_hf_div),
    .out_lvl(hf_raw), .synced(hf_synced)
  );

  assign hf_pol = hf_raw ^ cfg_hf_invert;
  assign hf_sel = (hf_src == SRC_INTERNAL) ? hf_pol : ext_hf_clk;

  rx_bclk_div #(.W(BIT_W)) u_bit_div (
    .clk(clk), .rst(rst), .in_lvl(hf_sel), .div(cfg_bit_div),
    .out_lvl(bit_raw), .synced(bit_synced)
  );

  assign bit_sel   = (bit_src == SRC_INTERNAL) ? bit_raw : ext_bclk;
  assign pin_ready = cfg_pin_drive & (bit_src == SRC_INTERNAL) & bit_synced &
                     ((hf_src == SRC_EXTERNAL) | hf_synced);

  rx_bclk_out u_out (
    .clk(clk), .rst(rst), .async_mode(cfg_async), .own_bclk(bit_sel),
    .tx_bclk(tx_bclk), .sample_rise(cfg_sample_rise), .pin_ready(pin_ready),
    .rx_bclk(rx_bclk), .rx_sample_rise(rx_sample_rise), .rx_pin_oe(rx_pin_oe)
  );

  assert_ext_bit_passthru_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(cfg_async && !cfg_bit_int)) |-> (rx_bclk == $past(ext_bclk)));

  assert_pin_needs_internal_R8: assert property (@(posedge clk) disable iff (rst)
    rx_pin_oe |-> $past(cfg_async && cfg_bit_int && cfg_pin_drive));

  assert_sample_edge_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(cfg_async)) |-> (rx_sample_rise == $past(cfg_sample_rise)));
endmodule

// File: tb/test_rx_bclk_gen.sv
module test_rx_bclk_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_clk = 0, ext_hf_clk = 0, ext_bclk = 0, tx_bclk = 0;
  logic cfg_async = 0, cfg_hf_int = 1, cfg_hf_invert = 0, cfg_bit_int = 1;
  logic [11:0] cfg_hf_div = 0;
  logic [4:0]  cfg_bit_div = 0;
  logic cfg_sample_rise = 0, cfg_pin_drive = 0;
  logic rx_bclk, rx_sample_rise, rx_pin_oe;

  int checks = 0, errors = 0, cyc = 0, gcnt = 0;
  string tag = "R10";
  bit done = 0;

  // reference model state
  int h_cnt, h_lim, b_cnt, b_lim;
  bit h_prev, b_prev, h_ld, b_ld;
  bit e_bclk, e_samp, e_oe;

  always #10 clk = ~clk;

  rx_bclk_gen i_rx_bclk_gen (
    .clk(clk), .rst(rst), .ref_clk(ref_clk), .ext_hf_clk(ext_hf_clk),
    .ext_bclk(ext_bclk), .tx_bclk(tx_bclk), .cfg_async(cfg_async),
    .cfg_hf_int(cfg_hf_int), .cfg_hf_invert(cfg_hf_invert), .cfg_hf_div(cfg_hf_div),
    .cfg_bit_int(cfg_bit_int), .cfg_bit_div(cfg_bit_div),
    .cfg_sample_rise(cfg_sample_rise), .cfg_pin_drive(cfg_pin_drive),
    .rx_bclk(rx_bclk), .rx_sample_rise(rx_sample_rise), .rx_pin_oe(rx_pin_oe)
  );

  function automatic bit lvl_of(int c, int l, bit inp);
    if (l == 0) return inp;
    return c < (l + 2) / 2;
  endfunction

  always @(posedge clk) begin
    bit hf, hs, bd, bs;
    if (rst) begin
      h_cnt = 0; h_lim = 0; b_cnt = 0; b_lim = 0;
      h_prev = 0; b_prev = 0; h_ld = 0; b_ld = 0;
      e_bclk = 0; e_samp = 0; e_oe = 0;
    end else begin
      hf = lvl_of(h_cnt, h_lim, ref_clk) ^ cfg_hf_invert;
      hs = cfg_hf_int ? hf : ext_hf_clk;
      bd = lvl_of(b_cnt, b_lim, hs);
      bs = cfg_bit_int ? bd : ext_bclk;
      e_bclk = cfg_async ? bs : !tx_bclk;
      e_samp = cfg_async ? cfg_sample_rise : 1'b1;
      e_oe = cfg_async && cfg_bit_int && cfg_pin_drive && b_ld && (b_lim == int'(cfg_bit_div))
             && (!cfg_hf_int || (h_ld && h_lim == int'(cfg_hf_div)));
      if (ref_clk && !h_prev) begin
        if (h_cnt == h_lim) begin h_cnt = 0; h_lim = int'(cfg_hf_div); h_ld = 1; end
        else h_cnt++;
      end
      h_prev = ref_clk;
      if (hs && !b_prev) begin
        if (b_cnt == b_lim) begin b_cnt = 0; b_lim = int'(cfg_bit_div); b_ld = 1; end
        else b_cnt++;
      end
      b_prev = hs;
    end
  end

  task automatic cmp(string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b cycle=%0d", tag, what, act, exp, cyc);
    end
  endtask

  // compare away from the active edge, then advance the free-running input clocks
  always @(negedge clk) begin
    if (!done) begin
      cmp("rx_bclk", rx_bclk, e_bclk);
      cmp("rx_sample_rise", rx_sample_rise, e_samp);
      cmp("rx_pin_oe", rx_pin_oe, e_oe);
      cyc++;
      gcnt++;
      ref_clk    <= gcnt[1];
      ext_hf_clk <= ((gcnt / 3) % 2) == 1;
      ext_bclk   <= ((gcnt / 5) % 2) == 1;
      tx_bclk    <= ((gcnt / 7) % 2) == 1;
      if (cyc > 190000) begin
        errors++;
        $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    tag = "R10"; run(6);
    rst = 0;
    tag = "R2";  cfg_async = 1; cfg_hf_div = 3; cfg_bit_div = 1; cfg_pin_drive = 1;
    cfg_sample_rise = 1; run(700);
    tag = "R9";  cfg_hf_div = 4; run(37); cfg_bit_div = 2; run(900);
    tag = "R5";  cfg_bit_div = 31; cfg_hf_div = 0; run(1200);
    tag = "R3";  cfg_hf_invert = 1; cfg_bit_div = 3; cfg_hf_div = 2; run(800);
    tag = "R4";  cfg_hf_int = 0; run(800);
    tag = "R7";  cfg_sample_rise = 0; run(50); cfg_sample_rise = 1; run(20);
    tag = "R6";  cfg_bit_int = 0; cfg_hf_int = 1; cfg_hf_div = 7; run(300);
    cfg_bit_div = 9; cfg_hf_invert = 0; run(300);
    tag = "R8";  cfg_bit_int = 1; cfg_pin_drive = 0; run(100); cfg_pin_drive = 1; run(400);
    tag = "R1";  cfg_async = 0; cfg_hf_div = 5; cfg_bit_div = 4; cfg_sample_rise = 0; run(500);
    tag = "R10"; rst = 1; run(4); rst = 0;
    tag = "R2";  cfg_async = 1; cfg_hf_div = 0; cfg_bit_div = 0; run(300);
    cfg_hf_div = 12'd4095; run(36000);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule